// File: doc/BRIEF.md
# Cache Tag Array Maintenance Port

This block gives software word-wide, memory-mapped access to the tag array of a four-way, 256-set data cache. The array is held inside the block as registers. Each line keeps a 19-bit tag, a dirty flag and a valid flag. An access carries a 32-bit address and a 32-bit data word. The address selects the port, a way, a set and one of two write flavours. The data word carries the tag together with the new dirty and valid flags.

There are three operations. A read returns the stored fields of one way. A direct write overwrites one way. An associative write searches all ways of a set for a valid line with a matching tag and changes only that line's flags. It is the usual way to invalidate or clean one line by address.

An associative write can first pass its virtual tag through an optional translation port and compare the returned physical tag instead. Whenever an update would drop dirty data, the block first requests a write-back of the line on an eviction port. It stays busy until that request is acknowledged.

Top module: `tag_maint_port`

## Requirements
- R1: After reset every stored tag, dirty flag and valid flag is zero. `acc_ready` is high, and `wb_req`, `xlat_req` and `acc_err` are low.
- R2: The block accepts an access only when `acc_valid` and `acc_ready` are both high and address bits [31:24] equal 0xF4. Any other access is ignored: it gives no read result, no error, no request and no change to the array.
- R3: An accepted access with address bits [1:0] nonzero changes nothing. It raises `acc_err` for exactly the one cycle after acceptance.
- R4: Address bits [14:13] select the way and bits [12:5] select the set. An accepted access with `acc_write`=0 is a read. In the cycle after acceptance it raises `rd_valid` and returns the tag in `rd_data[28:10]`, the dirty flag in bit 1 and the valid flag in bit 0; all other bits are zero. Address bit 3 has no effect on a read.
- R5: A write with address bit 3 clear stores data bits [28:10] as the tag, bit 1 as dirty and bit 0 as valid in the addressed way. Data bits [31:29] are ignored.
- R6: Before a line is overwritten, the block can request a write-back. It then pulses `wb_req` for one cycle, in the cycle after the decision, with the line's way, set and old tag. It holds `acc_ready` low until `wb_ack` is sampled high, stores the new values on the following clock edge and raises `acc_ready` again after that edge.
- R7: A write with address bit 3 set ignores address bits [14:13]. It compares the data tag (bits [28:10]) with every valid way of the addressed set. A matching way takes data bits [1] and [0] as its dirty and valid flags and keeps its tag.
- R8: An associative write that finds no valid way with a matching tag changes nothing and requests no write-back.
- R9: A write-back (R6) is needed by a direct write whose target line is dirty and valid. It is also needed by an associative write whose matched line is dirty and whose new dirty or new valid flag is zero. Otherwise the update takes effect on the accepting edge.
- R10: With `xlat_en` high, an associative write pulses `xlat_req` for one cycle, with `xlat_vtag` equal to data bits [31:10]. When `xlat_rsp_valid` is sampled, a high `xlat_miss` ends the operation with no change. Otherwise `xlat_ptag` takes the place of the data tag in the comparison.
- R11: If several valid ways of a set match in an associative write, only the lowest-numbered one is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| acc_valid | input | 1 | Access strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 32 | Access address (select, way, set, associate flag) |
| acc_wdata | input | 32 | Write data (tag, dirty, valid) |
| acc_ready | output | 1 | High when a new access can be accepted |
| rd_valid | output | 1 | Read result strobe |
| rd_data | output | 32 | Read result |
| acc_err | output | 1 | One-cycle misaligned-access flag |
| xlat_en | input | 1 | Translate associative-write tags |
| xlat_req | output | 1 | Translation request pulse |
| xlat_vtag | output | 22 | Virtual tag sent for translation |
| xlat_rsp_valid | input | 1 | Translation response strobe |
| xlat_miss | input | 1 | Translation miss with response |
| xlat_ptag | input | 19 | Translated physical tag |
| wb_req | output | 1 | Write-back request pulse |
| wb_ack | input | 1 | Write-back done |
| wb_way | output | 2 | Way of line to write back |
| wb_set | output | 8 | Set of line to write back |
| wb_tag | output | 19 | Stored tag of line to write back |

## Verification
Read data, `rd_valid` and `acc_err` are registered and appear one cycle after the accepting edge. Direct and untranslated associative updates are visible to a read started on the next cycle. `wb_req` and `xlat_req` rise one cycle after the edge that decides on them. A deferred update lands on the edge after the one that samples `wb_ack`. The bench drives on falling edges and samples on the falling edge that follows each edge of interest, so every check falls in the cycle in which its result is due. Every effect on the array is confirmed by reading it back through the port.

// File: rtl/tmp_pkg.sv
package tmp_pkg;
  localparam int unsigned SEL_LSB   = 24;
  localparam logic [7:0]  SEL_CODE  = 8'hF4;
  localparam int unsigned SET_LSB   = 5;
  localparam int unsigned ASSOC_BIT = 3;
  localparam int unsigned TAG_LSB   = 10;

  typedef enum logic [1:0] {ST_IDLE, ST_XLAT, ST_WB, ST_COMMIT} mp_state_e;

  function automatic logic f_selected(input logic [31:0] addr);
    return addr[31:SEL_LSB] == SEL_CODE;
  endfunction

  function automatic logic f_misaligned(input logic [31:0] addr);
    return addr[1:0] != 2'b00;
  endfunction

  // direct overwrite loses data when the old line is dirty and valid
  function automatic logic f_wb_direct(input logic old_d, input logic old_v);
    return old_d & old_v;
  endfunction

  // associative update loses data when a dirty line drops dirty or valid
  function automatic logic f_wb_assoc(input logic old_d, input logic new_d,
                                      input logic new_v);
    return old_d & (~new_d | ~new_v);
  endfunction

  function automatic logic [31:0] f_pack_read(input logic [31:0] tag_ext,
                                              input logic d, input logic v);
    return (tag_ext << TAG_LSB) | {30'b0, d, v};
  endfunction
endpackage

// File: rtl/tmp_tag_store.sv
module tmp_tag_store #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 19,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [SET_W-1:0]            rd_set,
  output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
  output logic [WAYS-1:0]             rd_d,
  output logic [WAYS-1:0]             rd_v,
  input  logic                        we,
  input  logic [WAY_W-1:0]            wr_way,
  input  logic [SET_W-1:0]            wr_set,
  input  logic [TAG_W-1:0]            wr_tag,
  input  logic                        wr_d,
  input  logic                        wr_v
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  d_q;
    logic [SETS-1:0]  v_q;
    logic             sel_w;

    assign sel_w = we && (wr_way == WAY_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int s = 0; s < SETS; s++) tag_q[s] <= '0;
        d_q <= '0;
        v_q <= '0;
      end else if (sel_w) begin
        tag_q[wr_set] <= wr_tag;
        d_q[wr_set]   <= wr_d;
        v_q[wr_set]   <= wr_v;
      end
    end

    assign rd_tag[w] = tag_q[rd_set];
    assign rd_d[w]   = d_q[rd_set];
    assign rd_v[w]   = v_q[rd_set];
  end
endmodule

// File: rtl/tmp_way_match.sv
module tmp_way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 19,
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
  input  logic [TAG_W-1:0]            cmp_tag,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0]             way_v,
  output logic [WAYS-1:0]             match_vec,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way
);
  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match_vec[w] = way_v[w] && (way_tag[w] == cmp_tag);
  end

  // lowest-numbered matching way wins
  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match_vec[w]) hit_way = WAY_W'(w);
    end
  end

  assign hit = |match_vec;
endmodule

// File: rtl/tmp_ctrl.sv
module tmp_ctrl
  import tmp_pkg::*;
#(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 19,
  localparam int WAY_W   = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W   = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int WAY_LSB = SET_LSB + SET_W,
  localparam int VTAG_W  = 32 - TAG_LSB
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        acc_valid,
  input  logic                        acc_write,
  input  logic [31:0]                 acc_addr,
  input  logic [31:0]                 acc_wdata,
  output logic                        acc_ready,
  output logic                        rd_valid,
  output logic [31:0]                 rd_data,
  output logic                        acc_err,
  input  logic                        xlat_en,
  output logic                        xlat_req,
  output logic [VTAG_W-1:0]           xlat_vtag,
  input  logic                        xlat_rsp_valid,
  input  logic                        xlat_miss,
  input  logic [TAG_W-1:0]            xlat_ptag,
  output logic                        wb_req,
  input  logic                        wb_ack,
  output logic [WAY_W-1:0]            wb_way,
  output logic [SET_W-1:0]            wb_set,
  output logic [TAG_W-1:0]            wb_tag,
  output logic [SET_W-1:0]            look_set,
  output logic [TAG_W-1:0]            cmp_tag,
  input  logic [WAYS-1:0][TAG_W-1:0]  set_tag,
  input  logic [WAYS-1:0]             set_d,
  input  logic [WAYS-1:0]             set_v,
  input  logic                        hit,
  input  logic [WAY_W-1:0]            hit_way,
  output logic                        st_we,
  output logic [WAY_W-1:0]            st_way,
  output logic [SET_W-1:0]            st_set,
  output logic [TAG_W-1:0]            st_tag,
  output logic                        st_d,
  output logic                        st_v,
  output logic                        in_xlat,
  output logic                        in_wb
);
  mp_state_e state_q, state_d;

  logic [SET_W-1:0] pend_set_q;
  logic [WAY_W-1:0] pend_way_q;
  logic [TAG_W-1:0] pend_tag_q;
  logic             pend_d_q, pend_v_q;

  logic idle, commit, fire, bad, good;
  logic is_rd, is_dw, is_aw, resolve_aw, do_upd, need_wb, upd_now, upd_wb;
  logic [WAY_W-1:0] addr_way, tgt_way;
  logic             new_d, new_v, old_d, old_v;
  logic [TAG_W-1:0] old_tag, new_tag;
  logic             unused_bits;

  assign idle     = (state_q == ST_IDLE);
  assign commit   = (state_q == ST_COMMIT);
  assign in_xlat  = (state_q == ST_XLAT);
  assign in_wb    = (state_q == ST_WB);
  assign acc_ready = idle;

  // access decode, only meaningful while idle
  assign fire  = acc_valid && idle && f_selected(acc_addr);
  assign bad   = fire && f_misaligned(acc_addr);
  assign good  = fire && !f_misaligned(acc_addr);
  assign is_rd = good && !acc_write;
  assign is_dw = good && acc_write && !acc_addr[ASSOC_BIT];
  assign is_aw = good && acc_write && acc_addr[ASSOC_BIT];

  assign addr_way = acc_addr[WAY_LSB +: WAY_W];
  assign look_set = idle ? acc_addr[SET_LSB +: SET_W] : pend_set_q;
  assign cmp_tag  = idle ? acc_wdata[TAG_LSB +: TAG_W] : xlat_ptag;
  assign new_d    = idle ? acc_wdata[1] : pend_d_q;
  assign new_v    = idle ? acc_wdata[0] : pend_v_q;

  // associative write resolves now, or when translation answers with a hit
  assign resolve_aw = (is_aw && !xlat_en) ||
                      (in_xlat && xlat_rsp_valid && !xlat_miss);
  assign do_upd  = is_dw || (resolve_aw && hit);
  assign tgt_way = is_dw ? addr_way : hit_way;
  assign old_tag = set_tag[tgt_way];
  assign old_d   = set_d[tgt_way];
  assign old_v   = set_v[tgt_way];
  assign new_tag = is_dw ? acc_wdata[TAG_LSB +: TAG_W] : old_tag;
  assign need_wb = is_dw ? f_wb_direct(old_d, old_v)
                         : f_wb_assoc(old_d, new_d, new_v);
  assign upd_now = do_upd && !need_wb;
  assign upd_wb  = do_upd && need_wb;

  // store write port: immediate update or deferred after write-back
  assign st_we  = upd_now || commit;
  assign st_way = commit ? pend_way_q : tgt_way;
  assign st_set = commit ? pend_set_q : look_set;
  assign st_tag = commit ? pend_tag_q : new_tag;
  assign st_d   = commit ? pend_d_q   : new_d;
  assign st_v   = commit ? pend_v_q   : new_v;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (upd_wb) state_d = ST_WB;
                 else if (is_aw && xlat_en) state_d = ST_XLAT;
      ST_XLAT:   if (xlat_rsp_valid) state_d = upd_wb ? ST_WB : ST_IDLE;
      ST_WB:     if (wb_ack) state_d = ST_COMMIT;
      ST_COMMIT: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      pend_set_q <= '0;
      pend_way_q <= '0;
      pend_tag_q <= '0;
      pend_d_q   <= 1'b0;
      pend_v_q   <= 1'b0;
      rd_valid   <= 1'b0;
      rd_data    <= '0;
      acc_err    <= 1'b0;
      xlat_req   <= 1'b0;
      xlat_vtag  <= '0;
      wb_req     <= 1'b0;
      wb_way     <= '0;
      wb_set     <= '0;
      wb_tag     <= '0;
    end else begin
      state_q  <= state_d;
      rd_valid <= is_rd;
      acc_err  <= bad;
      xlat_req <= is_aw && xlat_en;
      wb_req   <= upd_wb;
      if (good) begin
        pend_set_q <= acc_addr[SET_LSB +: SET_W];
        pend_d_q   <= acc_wdata[1];
        pend_v_q   <= acc_wdata[0];
      end
      if (is_rd)
        rd_data <= f_pack_read(32'(set_tag[addr_way]), set_d[addr_way],
                               set_v[addr_way]);
      if (is_aw && xlat_en) xlat_vtag <= acc_wdata[31:TAG_LSB];
      if (upd_wb) begin
        pend_way_q <= tgt_way;
        pend_tag_q <= new_tag;
        wb_way     <= tgt_way;
        wb_set     <= look_set;
        wb_tag     <= old_tag;
      end
    end
  end

  assign unused_bits = ^{acc_wdata[TAG_LSB-1:2], acc_addr[SEL_LSB-1:WAY_LSB+WAY_W],
                         acc_addr[ASSOC_BIT+1], acc_addr[2]};
endmodule

// File: rtl/tag_maint_port.sv
module tag_maint_port #(
  parameter int WAYS  = 4,
  parameter int SETS  = 256,
  parameter int TAG_W = 19,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SET_W  = (SETS > 1) ? $clog2(SETS) : 1,
  localparam int VTAG_W = 32 - tmp_pkg::TAG_LSB
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic [31:0]       acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              acc_ready,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  output logic              acc_err,
  input  logic              xlat_en,
  output logic              xlat_req,
  output logic [VTAG_W-1:0] xlat_vtag,
  input  logic              xlat_rsp_valid,
  input  logic              xlat_miss,
  input  logic [TAG_W-1:0]  xlat_ptag,
  output logic              wb_req,
  input  logic              wb_ack,
  output logic [WAY_W-1:0]  wb_way,
  output logic [SET_W-1:0]  wb_set,
  output logic [TAG_W-1:0]  wb_tag
);
  logic [SET_W-1:0]             look_set;
  logic [TAG_W-1:0]             cmp_tag;
  logic [WAYS-1:0][TAG_W-1:0]   set_tag;
  logic [WAYS-1:0]              set_d, set_v, match_vec;
  logic                         hit;
  logic [WAY_W-1:0]             hit_way;
  logic                         st_we, st_d, st_v;
  logic [WAY_W-1:0]             st_way;
  logic [SET_W-1:0]             st_set;
  logic [TAG_W-1:0]             st_tag;
  logic                         in_xlat, in_wb;

  tmp_tag_store #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_set(look_set), .rd_tag(set_tag),
    .rd_d(set_d), .rd_v(set_v), .we(st_we), .wr_way(st_way),
    .wr_set(st_set), .wr_tag(st_tag), .wr_d(st_d), .wr_v(st_v)
  );

  tmp_way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .cmp_tag(cmp_tag), .way_tag(set_tag), .way_v(set_v),
    .match_vec(match_vec), .hit(hit), .hit_way(hit_way)
  );

  tmp_ctrl #(.WAYS(WAYS), .SETS(SETS), .TAG_W(TAG_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_ready(acc_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .acc_err(acc_err),
    .xlat_en(xlat_en), .xlat_req(xlat_req), .xlat_vtag(xlat_vtag),
    .xlat_rsp_valid(xlat_rsp_valid), .xlat_miss(xlat_miss),
    .xlat_ptag(xlat_ptag), .wb_req(wb_req), .wb_ack(wb_ack),
    .wb_way(wb_way), .wb_set(wb_set), .wb_tag(wb_tag),
    .look_set(look_set), .cmp_tag(cmp_tag), .set_tag(set_tag),
    .set_d(set_d), .set_v(set_v), .hit(hit), .hit_way(hit_way),
    .st_we(st_we), .st_way(st_way), .st_set(st_set), .st_tag(st_tag),
    .st_d(st_d), .st_v(st_v), .in_xlat(in_xlat), .in_wb(in_wb)
  );
endmodule

// File: rtl/tmp_checker.sv
module tmp_checker #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 19
) (
  input logic            clk,
  input logic            rst_n,
  input logic            acc_valid,
  input logic [31:0]     acc_addr,
  input logic            acc_ready,
  input logic            rd_valid,
  input logic [31:0]     rd_data,
  input logic            acc_err,
  input logic            xlat_req,
  input logic            xlat_rsp_valid,
  input logic            xlat_miss,
  input logic            wb_req,
  input logic            wb_ack,
  input logic            st_we,
  input logic            in_xlat,
  input logic            in_wb,
  input logic [WAYS-1:0] match_vec
);
  AST_UNSEL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_ready && acc_addr[31:24] != 8'hF4) |=>
      (!rd_valid && !acc_err && !wb_req && !xlat_req && acc_ready)); // R2

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |=> !acc_err); // R3

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> ($past(acc_addr[1:0]) != 2'b00)); // R3

  AST_READ_ZERO_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (rd_data[9:2] == 8'h00 && (rd_data >> (10 + TAG_W)) == 32'h0)); // R4

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, acc_err, wb_req, xlat_req})); // R4

  AST_WB_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wb_req |=> !wb_req); // R6

  AST_WB_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    in_wb |-> !acc_ready); // R6

  AST_WB_NO_EARLY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wb && !wb_ack) |-> !st_we); // R6

  AST_XLAT_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    xlat_req |=> !xlat_req); // R10

  AST_MISS_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xlat && xlat_rsp_valid && xlat_miss) |-> (!st_we ##1 acc_ready)); // R10

  AST_MATCH_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xlat && !xlat_rsp_valid) |-> !st_we); // R10

  AST_MATCH_VEC_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    !$isunknown(match_vec)); // R11
endmodule

bind tag_maint_port tmp_checker #(.WAYS(WAYS), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_addr(acc_addr),
  .acc_ready(acc_ready), .rd_valid(rd_valid), .rd_data(rd_data),
  .acc_err(acc_err), .xlat_req(xlat_req), .xlat_rsp_valid(xlat_rsp_valid),
  .xlat_miss(xlat_miss), .wb_req(wb_req), .wb_ack(wb_ack), .st_we(st_we),
  .in_xlat(in_xlat), .in_wb(in_wb), .match_vec(match_vec)
);

// File: tb/tag_maint_port_bench.sv
`timescale 1ns/1ps
module tag_maint_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        acc_valid = 1'b0, acc_write = 1'b0;
  logic [31:0] acc_addr = '0, acc_wdata = '0;
  logic        acc_ready, rd_valid, acc_err;
  logic [31:0] rd_data;
  logic        xlat_en = 1'b0, xlat_req, xlat_rsp_valid = 1'b0, xlat_miss = 1'b0;
  logic [21:0] xlat_vtag;
  logic [18:0] xlat_ptag = '0;
  logic        wb_req, wb_ack = 1'b0;
  logic [1:0]  wb_way;
  logic [7:0]  wb_set;
  logic [18:0] wb_tag;

  int checks = 0;
  int fails  = 0;

  logic [18:0] m_tag [4][256];
  bit          m_d   [4][256];
  bit          m_v   [4][256];

  always #2.5 clk = ~clk;

  tag_maint_port u_tag_maint_port (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_addr(input int way, input int set, input bit assoc);
    return 32'hF400_0000 | (32'(way) << 13) | (32'(set) << 5) | (32'(assoc) << 3);
  endfunction

  function automatic logic [31:0] mk_data(input logic [21:0] t, input bit d, input bit v);
    return {t, 8'h00, d, v};
  endfunction

  function automatic logic [31:0] exp_word(input int way, input int set);
    return {3'b000, m_tag[way][set], 8'h00, m_d[way][set], m_v[way][set]};
  endfunction

  // drive at a falling edge, return at the falling edge after acceptance
  task automatic access(input bit wr, input logic [31:0] addr, input logic [31:0] data);
    acc_valid = 1'b1; acc_write = wr; acc_addr = addr; acc_wdata = data;
    @(negedge clk);
    acc_valid = 1'b0; acc_write = 1'b0;
  endtask

  task automatic read_chk(input string req, input int way, input int set, input bit assoc);
    access(1'b0, mk_addr(way, set, assoc), 32'h0);
    chk({req, " rd_valid"}, 32'(rd_valid), 32'h1);
    chk({req, " rd_data"}, rd_data, exp_word(way, set));
  endtask

  // direct write expected to take effect immediately
  task automatic dwrite(input int way, input int set, input logic [21:0] t, input bit d, input bit v);
    access(1'b1, mk_addr(way, set, 1'b0), mk_data(t, d, v));
    chk("R9 no write-back on clean direct write", 32'(wb_req), 32'h0);
    m_tag[way][set] = t[18:0]; m_d[way][set] = d; m_v[way][set] = v;
  endtask

  // called at the falling edge where wb_req is high
  task automatic finish_wb(input string req);
    @(negedge clk);
    chk({req, " wb_req one cycle"}, 32'(wb_req), 32'h0);
    @(negedge clk);
    chk({req, " busy while waiting"}, 32'(acc_ready), 32'h0);
    wb_ack = 1'b1;
    @(negedge clk);
    wb_ack = 1'b0;
    chk({req, " busy on commit cycle"}, 32'(acc_ready), 32'h0);
    @(negedge clk);
    chk({req, " ready after commit"}, 32'(acc_ready), 32'h1);
  endtask

  task automatic t_reset;
    chk("R1 ready", 32'(acc_ready), 32'h1);
    chk("R1 wb_req", 32'(wb_req), 32'h0);
    chk("R1 xlat_req", 32'(xlat_req), 32'h0);
    chk("R1 acc_err", 32'(acc_err), 32'h0);
    read_chk("R1 array zero", 0, 0, 1'b0);
    read_chk("R1 array zero", 3, 255, 1'b0);
  endtask

  task automatic t_direct;
    dwrite(2, 8'h15, 22'h3D_A5A5, 1'b0, 1'b1);
    read_chk("R5 direct write, bits 31:29 dropped", 2, 8'h15, 1'b0);
    read_chk("R4 associate flag ignored on read", 2, 8'h15, 1'b1);
    read_chk("R4 other way untouched", 1, 8'h15, 1'b0);
  endtask

  task automatic t_unselected;
    access(1'b1, mk_addr(2, 8'h15, 1'b0) ^ 32'h0100_0000, mk_data(22'h0, 1'b0, 1'b0));
    chk("R2 no error on unselected", 32'(acc_err), 32'h0);
    chk("R2 no result on unselected", 32'(rd_valid), 32'h0);
    access(1'b0, 32'h1234_0000, 32'h0);
    chk("R2 unselected read no rd_valid", 32'(rd_valid), 32'h0);
    read_chk("R2 array unchanged", 2, 8'h15, 1'b0);
  endtask

  task automatic t_misaligned;
    access(1'b1, mk_addr(2, 8'h15, 1'b0) | 32'h2, mk_data(22'h0, 1'b0, 1'b0));
    chk("R3 error raised", 32'(acc_err), 32'h1);
    chk("R3 no read result", 32'(rd_valid), 32'h0);
    @(negedge clk);
    chk("R3 error one cycle", 32'(acc_err), 32'h0);
    read_chk("R3 array unchanged", 2, 8'h15, 1'b0);
  endtask

  task automatic t_direct_wb;
    dwrite(1, 7, 22'h01_2345, 1'b1, 1'b1);
    access(1'b1, mk_addr(1, 7, 1'b0), mk_data(22'h00_0777, 1'b0, 1'b1));
    chk("R6 wb_req raised", 32'(wb_req), 32'h1);
    chk("R6 wb_way", 32'(wb_way), 32'h1);
    chk("R6 wb_set", 32'(wb_set), 32'h7);
    chk("R6 wb_tag old", 32'(wb_tag), 32'h1_2345);
    chk("R6 busy", 32'(acc_ready), 32'h0);
    finish_wb("R6");
    m_tag[1][7] = 19'h0_0777; m_d[1][7] = 1'b0; m_v[1][7] = 1'b1;
    read_chk("R5 value after write-back", 1, 7, 1'b0);
  endtask

  task automatic t_assoc;
    dwrite(0, 8'h40, 22'h0_AAAA, 1'b0, 1'b1);
    dwrite(2, 8'h40, 22'h0_BBBB, 1'b0, 1'b1);
    dwrite(3, 8'h40, 22'h0_BBBB, 1'b0, 1'b0);
    access(1'b1, mk_addr(3, 8'h40, 1'b1), mk_data(22'h0_BBBB, 1'b0, 1'b0));
    chk("R7 clean line no write-back", 32'(wb_req), 32'h0);
    m_v[2][8'h40] = 1'b0;
    read_chk("R7 matching valid way updated", 2, 8'h40, 1'b0);
    read_chk("R7 invalid way untouched", 3, 8'h40, 1'b0);
    read_chk("R7 other tag untouched", 0, 8'h40, 1'b0);
  endtask

  task automatic t_nomatch;
    access(1'b1, mk_addr(0, 8'h40, 1'b1), mk_data(22'h0_CCCC, 1'b0, 1'b0));
    chk("R8 no write-back", 32'(wb_req), 32'h0);
    access(1'b1, mk_addr(0, 8'h40, 1'b1), mk_data(22'h0_BBBB, 1'b1, 1'b1));
    for (int w = 0; w < 4; w++) read_chk("R8 set unchanged", w, 8'h40, 1'b0);
  endtask

  task automatic t_assoc_wb;
    dwrite(0, 8'h40, 22'h0_AAAA, 1'b1, 1'b1);
    access(1'b1, mk_addr(2, 8'h40, 1'b1), mk_data(22'h0_AAAA, 1'b1, 1'b1));
    chk("R9 dirty kept, no write-back", 32'(wb_req), 32'h0);
    access(1'b1, mk_addr(2, 8'h40, 1'b1), mk_data(22'h0_AAAA, 1'b0, 1'b1));
    chk("R9 dirty dropped, write-back", 32'(wb_req), 32'h1);
    chk("R9 wb_way is matched way", 32'(wb_way), 32'h0);
    chk("R9 wb_tag", 32'(wb_tag), 32'h0_AAAA);
    finish_wb("R9");
    m_d[0][8'h40] = 1'b0;
    read_chk("R9 flags after write-back", 0, 8'h40, 1'b0);
  endtask

  task automatic t_multi;
    dwrite(1, 8'h41, 22'h0_DDDD, 1'b0, 1'b1);
    dwrite(3, 8'h41, 22'h0_DDDD, 1'b0, 1'b1);
    access(1'b1, mk_addr(3, 8'h41, 1'b1), mk_data(22'h0_DDDD, 1'b0, 1'b0));
    m_v[1][8'h41] = 1'b0;
    read_chk("R11 lowest way updated", 1, 8'h41, 1'b0);
    read_chk("R11 higher way untouched", 3, 8'h41, 1'b0);
  endtask

  task automatic t_xlat;
    dwrite(2, 8'h42, 22'h1_E1E1, 1'b1, 1'b1);
    xlat_en = 1'b1;
    access(1'b1, mk_addr(0, 8'h42, 1'b1), mk_data(22'h3C_0F0F, 1'b0, 1'b1));
    chk("R10 xlat_req", 32'(xlat_req), 32'h1);
    chk("R10 xlat_vtag", 32'(xlat_vtag), 32'h3C_0F0F);
    chk("R10 busy during translation", 32'(acc_ready), 32'h0);
    @(negedge clk);
    chk("R10 xlat_req one cycle", 32'(xlat_req), 32'h0);
    xlat_rsp_valid = 1'b1; xlat_miss = 1'b1; xlat_ptag = 19'h1_E1E1;
    @(negedge clk);
    xlat_rsp_valid = 1'b0; xlat_miss = 1'b0;
    chk("R10 miss ends operation", 32'(acc_ready), 32'h1);
    chk("R10 miss no write-back", 32'(wb_req), 32'h0);
    read_chk("R10 miss leaves line", 2, 8'h42, 1'b0);
    access(1'b1, mk_addr(0, 8'h42, 1'b1), mk_data(22'h3C_0F0F, 1'b0, 1'b1));
    @(negedge clk);
    xlat_rsp_valid = 1'b1; xlat_ptag = 19'h1_E1E1;
    @(negedge clk);
    xlat_rsp_valid = 1'b0;
    chk("R10 physical tag hit write-back", 32'(wb_req), 32'h1);
    chk("R10 wb_way", 32'(wb_way), 32'h2);
    finish_wb("R10");
    xlat_en = 1'b0;
    m_d[2][8'h42] = 1'b0;
    read_chk("R10 updated by physical tag", 2, 8'h42, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    for (int w = 0; w < 4; w++)
      for (int s = 0; s < 256; s++) begin
        m_tag[w][s] = '0; m_d[w][s] = 1'b0; m_v[w][s] = 1'b0;
      end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_direct();
    t_unselected();
    t_misaligned();
    t_direct_wb();
    t_assoc();
    t_nomatch();
    t_assoc_wb();
    t_multi();
    t_xlat();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule